// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Generator

This block sequences the row-select strobe of a 40-output dot-matrix LCD driver and works out the role of each output. The outputs form five groups of eight. The first group always drives rows. The last group always drives columns, or stays idle in all-row mode. The three middle groups switch between row and column as a whole group. A step enable moves the scan from one row to the next. A two-bit rate code sets how many rows the scan covers (8, 16, 24 or 32), and a mode input chooses between mixed mode (rows plus columns) and all-row mode.

The block exposes the current row index so that column data can be fetched in step with the scan. It raises a one-cycle flag each time the scan wraps back to row 0. At the two lower rates, in all-row mode, the select strobe is copied onto every bank that holds that row. This lets one panel be split into two or four areas that are driven at the same time. The strobe is only ever driven on an output whose current role is row.

Top module: `lcd_row_scan`

## Requirements
- R1: Rate code 0, 1, 2 and 3 selects a scan of 8, 16, 24 and 32 rows. `row_idx` runs from 0 up to that count minus one and then returns to 0.
- R2: On a clock edge where `step_en` is high and the configuration is unchanged, `row_idx` increases by one. When `step_en` is low, `row_idx` and `row_sel` hold their values.
- R3: `frame_start` is high for exactly the one cycle after the step that moves `row_idx` from the last row back to 0. It is low at all other times.
- R4: If `mux_rate` or `row_mode` differs from its value at the previous edge, `row_idx` becomes 0 and `frame_start` stays low. This overrides any step on that edge.
- R5: Outputs 0–7 are always marked as rows and never as columns, in every mode, in every rate and during reset.
- R6: In mixed mode (`row_mode`=0), middle group g (g = 1, 2 or 3, covering outputs 8g to 8g+7) is a row group when g is at most the rate code, and a column group otherwise. Outputs 32–39 are columns.
- R7: In all-row mode (`row_mode`=1), outputs 0–31 are rows and outputs 32–39 are neither rows nor columns. No output is ever marked as both.
- R8: `row_sel` bit k is high only when output k is a row and k matches the current row. At rates 2 and 3, and in mixed mode, exactly one bit is high: bit `row_idx`. Bits 32–39 are always low.
- R9: In all-row mode at rate 0, bits `row_idx`, +8, +16 and +24 are high together. At rate 1, bits `row_idx` and `row_idx`+16 are high together.
- R10: While `rst_n` is low, `row_sel` is all zero, `row_idx` is 0 and `frame_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_en | input | 1 | Advance the scan by one row on this edge |
| mux_rate | input | 2 | Rate code: 0=1:8, 1=1:16, 2=1:24, 3=1:32 |
| row_mode | input | 1 | 1 = all-row mode, 0 = mixed mode |
| row_sel | output | 40 | Registered row-select strobe, one bit per output |
| is_row | output | 40 | Output is currently a row driver |
| is_col | output | 40 | Output is currently a column driver |
| row_idx | output | 5 | Current row index of the scan |
| frame_start | output | 1 | One-cycle pulse after the scan wraps to row 0 |

## Verification
The hardest situations to reach are a configuration change that lands on the same edge as a step, especially on the last row where a wrap would otherwise fire. All-row mode at the low rates, where replicated strobes appear on four banks, is also rarely reached. The directed phases force a rate change while `step_en` is held high in the middle of a scan. They also sweep all-row mode at rates 0 and 1 across complete frames. A long random phase then changes rate and mode at random moments, so that some changes fall on last-row steps, and checks every output each cycle against a bench reference model.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int RATE_W     = 2;
  localparam int SCAN_GRPS  = 1 << RATE_W;   // groups that can carry rows
  localparam int TOTAL_GRPS = SCAN_GRPS + 1; // plus the fixed column group

  typedef enum logic [RATE_W-1:0] {
    MUX_8  = 2'd0,
    MUX_16 = 2'd1,
    MUX_24 = 2'd2,
    MUX_32 = 2'd3
  } mux_rate_e;
endpackage

// File: rtl/lcd_row_counter.sv
module lcd_row_counter
  import lcd_scan_pkg::*;
#(
  parameter int GRP   = 8,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [RATE_W-1:0] mux_rate,
  input  logic              row_mode,
  output logic [IDX_W-1:0]  idx_q,
  output logic [IDX_W-1:0]  idx_d,
  output logic              frame_q
);
  logic [RATE_W:0]  cfg_q;
  logic [RATE_W:0]  cfg_now;
  logic             cfg_chg;
  logic [IDX_W-1:0] last_idx;
  logic             frame_d;

  assign cfg_now  = {mux_rate, row_mode};
  assign cfg_chg  = (cfg_now != cfg_q);
  assign last_idx = IDX_W'(GRP * (int'(mux_rate) + 1) - 1);

  always_comb begin
    idx_d   = idx_q;
    frame_d = 1'b0;
    if (cfg_chg) begin
      idx_d = '0;
    end else if (step_en) begin
      if (idx_q == last_idx) begin
        idx_d   = '0;
        frame_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      frame_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      idx_q   <= idx_d;
      frame_q <= frame_d;
      cfg_q   <= cfg_now;
    end
  end
endmodule

// File: rtl/lcd_role_map.sv
module lcd_role_map
  import lcd_scan_pkg::*;
#(
  parameter int GRP = 8,
  localparam int N_OUT = TOTAL_GRPS * GRP
) (
  input  logic [RATE_W-1:0] mux_rate,
  input  logic              row_mode,
  output logic [N_OUT-1:0]  is_row,
  output logic [N_OUT-1:0]  is_col
);
  for (genvar g = 0; g < TOTAL_GRPS; g++) begin : g_grp
    if (g == 0) begin : g_fixed_row
      assign is_row[g*GRP +: GRP] = {GRP{1'b1}};
      assign is_col[g*GRP +: GRP] = {GRP{1'b0}};
    end else if (g == TOTAL_GRPS - 1) begin : g_fixed_col
      assign is_row[g*GRP +: GRP] = {GRP{1'b0}};
      assign is_col[g*GRP +: GRP] = {GRP{!row_mode}};
    end else begin : g_prog
      logic needed;
      assign needed = row_mode || (int'(mux_rate) >= g);
      assign is_row[g*GRP +: GRP] = {GRP{needed}};
      assign is_col[g*GRP +: GRP] = {GRP{!needed}};
    end
  end
endmodule

// File: rtl/lcd_select_decode.sv
module lcd_select_decode
  import lcd_scan_pkg::*;
#(
  parameter int GRP   = 8,
  parameter int IDX_W = 5,
  localparam int N_OUT  = TOTAL_GRPS * GRP,
  localparam int N_SCAN = SCAN_GRPS * GRP
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [RATE_W-1:0] mux_rate,
  input  logic [N_OUT-1:0]  is_row,
  output logic [N_OUT-1:0]  sel
);
  always_comb begin
    sel = '0;
    for (int k = 0; k < N_SCAN; k++) begin
      logic hit;
      case (mux_rate_e'(mux_rate))
        MUX_8:   hit = (IDX_W'(k % GRP) == idx);
        MUX_16:  hit = (IDX_W'(k % (2 * GRP)) == idx);
        default: hit = (IDX_W'(k) == idx);
      endcase
      sel[k] = hit && is_row[k];
    end
  end
endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int GRP = 8,
  localparam int N_OUT = TOTAL_GRPS * GRP,
  localparam int IDX_W = $clog2(SCAN_GRPS * GRP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [RATE_W-1:0] mux_rate,
  input  logic              row_mode,
  output logic [N_OUT-1:0]  row_sel,
  output logic [N_OUT-1:0]  is_row,
  output logic [N_OUT-1:0]  is_col,
  output logic [IDX_W-1:0]  row_idx,
  output logic              frame_start
);
  logic [IDX_W-1:0] idx_d;
  logic [N_OUT-1:0] sel_d;

  lcd_row_counter #(.GRP(GRP), .IDX_W(IDX_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .mux_rate (mux_rate),
    .row_mode (row_mode),
    .idx_q    (row_idx),
    .idx_d    (idx_d),
    .frame_q  (frame_start)
  );

  lcd_role_map #(.GRP(GRP)) u_roles (
    .mux_rate (mux_rate),
    .row_mode (row_mode),
    .is_row   (is_row),
    .is_col   (is_col)
  );

  lcd_select_decode #(.GRP(GRP), .IDX_W(IDX_W)) u_dec (
    .idx      (idx_d),
    .mux_rate (mux_rate),
    .is_row   (is_row),
    .sel      (sel_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_sel <= '0;
    else        row_sel <= sel_d;
  end
endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk
  import lcd_scan_pkg::*;
#(
  parameter int GRP = 8,
  localparam int N_OUT = TOTAL_GRPS * GRP,
  localparam int IDX_W = $clog2(SCAN_GRPS * GRP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_en,
  input logic [RATE_W-1:0] mux_rate,
  input logic              row_mode,
  input logic [N_OUT-1:0]  row_sel,
  input logic [N_OUT-1:0]  is_row,
  input logic [N_OUT-1:0]  is_col,
  input logic [IDX_W-1:0]  row_idx,
  input logic              frame_start
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  function automatic logic [IDX_W-1:0] top_row(logic [RATE_W-1:0] r);
    return IDX_W'(GRP * (int'(r) + 1) - 1);
  endfunction

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (row_sel == '0 && row_idx == '0 && !frame_start));

  // R5
  fixed_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_row[GRP-1:0] == {GRP{1'b1}}) && (is_col[GRP-1:0] == '0));

  // R7
  role_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_row & is_col) == '0);

  // R3
  frame_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> row_idx == '0);

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> row_idx <= top_row($past(mux_rate)));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && step_en && mux_rate == $past(mux_rate) && row_mode == $past(row_mode)
     && row_idx != top_row(mux_rate))
    |=> row_idx == $past(row_idx) + 1'b1);

  // R4
  cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (mux_rate != $past(mux_rate) || row_mode != $past(row_mode)))
    |=> (row_idx == '0 && !frame_start));

  // R8
  sel_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mux_rate == $past(mux_rate) && row_mode == $past(row_mode))
    |-> (row_sel & ~is_row) == '0);

  // R8
  single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mux_rate == $past(mux_rate) && row_mode == $past(row_mode) && !row_mode)
    |-> $countones(row_sel) == 1);

  // R9
  quad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mux_rate == $past(mux_rate) && row_mode == $past(row_mode)
     && row_mode && mux_rate == 2'd0)
    |-> $countones(row_sel) == 4);
endmodule

bind lcd_row_scan lcd_row_scan_chk #(.GRP(GRP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_en     (step_en),
  .mux_rate    (mux_rate),
  .row_mode    (row_mode),
  .row_sel     (row_sel),
  .is_row      (is_row),
  .is_col      (is_col),
  .row_idx     (row_idx),
  .frame_start (frame_start)
);

// File: tb/lcd_row_scan_test.sv
`timescale 1ns/1ps
module lcd_row_scan_test;
  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [1:0]  mux_rate;
  logic        row_mode;
  logic [39:0] row_sel, is_row, is_col;
  logic [4:0]  row_idx;
  logic        frame_start;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  int m_idx;
  bit m_fs;
  int m_rate_prev;
  bit m_mode_prev;
  bit m_in_reset;

  lcd_row_scan uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .mux_rate(mux_rate),
    .row_mode(row_mode), .row_sel(row_sel), .is_row(is_row), .is_col(is_col),
    .row_idx(row_idx), .frame_start(frame_start)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [39:0] exp_row(int rate, bit mode);
    logic [39:0] v;
    for (int k = 0; k < 40; k++) begin
      int g;
      g = k / 8;
      if (g == 0) v[k] = 1'b1;
      else if (g == 4) v[k] = 1'b0;
      else v[k] = mode || (g <= rate);
    end
    return v;
  endfunction

  function automatic logic [39:0] exp_col(int rate, bit mode);
    logic [39:0] v;
    for (int k = 0; k < 40; k++) begin
      int g;
      g = k / 8;
      if (g == 0) v[k] = 1'b0;
      else if (g == 4) v[k] = !mode;
      else v[k] = !(mode || (g <= rate));
    end
    return v;
  endfunction

  function automatic logic [39:0] exp_sel(int idx, int rate, bit mode);
    logic [39:0] v, rows;
    int n;
    n = 8 * (rate + 1);
    rows = exp_row(rate, mode);
    v = '0;
    for (int k = 0; k < 32; k++) begin
      bit hit;
      hit = (k == idx);
      if (mode && rate <= 1 && (k % n) == idx) hit = 1'b1;
      v[k] = hit && rows[k];
    end
    return v;
  endfunction

  task automatic model_edge();
    if (m_in_reset) begin
      m_idx = 0; m_fs = 0; m_rate_prev = 0; m_mode_prev = 0;
    end else begin
      if (int'(mux_rate) != m_rate_prev || row_mode != m_mode_prev) begin
        m_idx = 0; m_fs = 0;
      end else if (step_en) begin
        if (m_idx == 8 * (int'(mux_rate) + 1) - 1) begin
          m_idx = 0; m_fs = 1;
        end else begin
          m_idx = m_idx + 1; m_fs = 0;
        end
      end else begin
        m_fs = 0;
      end
      m_rate_prev = int'(mux_rate);
      m_mode_prev = row_mode;
    end
  endtask

  task automatic chk(string tag, string what, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    logic [39:0] es;
    es = m_in_reset ? 40'd0 : exp_sel(m_idx, int'(mux_rate), row_mode);
    chk(tag, "row_idx", 40'(row_idx), 40'(m_idx));
    chk(tag, "frame_start", 40'(frame_start), 40'(m_fs));
    chk(tag, "row_sel", row_sel, es);
    chk(tag, "is_row", is_row, exp_row(int'(mux_rate), row_mode));
    chk(tag, "is_col", is_col, exp_col(int'(mux_rate), row_mode));
  endtask

  // one clock: inputs already set at a negedge; compare at the next negedge
  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b1; step_en = 1'b1; mux_rate = 2'd0; row_mode = 1'b0;
    m_in_reset = 1;
    #1 rst_n = 1'b0;
    // R10: outputs quiet while reset is held even with step_en high
    run(3, "R10");
    @(negedge clk); rst_n = 1'b1; m_in_reset = 0;
    step_en = 1'b0;
    run(2, "R10");

    // R1 / R3: full 1:32 mixed scans with wrap
    mux_rate = 2'd3; step_en = 1'b1;
    run(2, "R4");
    run(70, "R1");
    run(3, "R3");

    // R2: hold without steps
    step_en = 1'b0;
    run(5, "R2");
    step_en = 1'b1;
    run(6, "R2");

    // R4: change rate mid-scan while stepping, also on the last row
    mux_rate = 2'd1;
    run(1, "R4");
    run(15, "R4");
    mux_rate = 2'd2;
    run(3, "R4");

    // R9: all-row mode replicas at 1:8 and 1:16
    row_mode = 1'b1; mux_rate = 2'd0;
    run(20, "R9");
    mux_rate = 2'd1;
    run(36, "R9");
    // R7: all-row roles at other rates
    mux_rate = 2'd2;
    run(30, "R7");
    mux_rate = 2'd3;
    run(10, "R7");

    // R6 / R5: mixed mode, each rate
    row_mode = 1'b0;
    for (int r = 0; r < 4; r++) begin
      mux_rate = 2'(r);
      run(12, "R6");
      run(2, "R5");
    end

    // R8: constrained random mix
    for (int i = 0; i < 4000; i++) begin
      step_en = ($urandom % 10) < 7;
      if (($urandom % 40) == 0) mux_rate = 2'($urandom % 4);
      if (($urandom % 60) == 0) row_mode = ~row_mode;
      cyc("R8");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule